// File: doc/BRIEF.md
# Transmit Burst Framer for a 16-bit Packet Interface

The framer accepts packet words from an upstream source and turns them into a single-rate, 16-bit word-serial transmit stream with a control/data flag. Each packet is cut into bursts. No burst is longer than a programmable cap, given as a count of 16-byte blocks (eight words per block). Each burst is led by a payload control word that carries the start-of-packet marker and the port address. When there is nothing to send, or when packet starts must be held apart, the gaps are filled with idle control words.

The cap comes from one of two programmable block counts, and `burst_sel` picks which one applies at each payload control word. The source presents a packet as a contiguous run of words from `in_sop` to `in_eop`. Once the framer accepts the first word it keeps `in_valid` high until the end-of-packet word is taken. The end-of-packet status, including a one-valid-byte indication for odd-length packets, travels in the first control word after the packet's last data word. With `pad_en` set, packets shorter than the minimum frame size are extended with zero words.

Top module: `pkt_burst_framer`

## Requirements
- R1: `tx_ctl` is 1 while `tx_word` holds a control word and 0 while it holds a data word. In reset and on the first cycle after it, the output is the idle control word 16'h0000 with `tx_ctl`=1.
- R2: Control word layout: bit 15 is 1 for payload and 0 for idle; bit 12 is start-of-packet; bits 11:4 are the port, zero-extended. Every burst is led by a payload control word on the cycle just before its first data word. Only the first burst of a packet has bit 12 set.
- R3: The cap in words is 8 times the block count chosen by `burst_sel` (0 picks `max_blk_a`, 1 picks `max_blk_b`). A block count of 0 counts as 1. Every burst of a packet except the last is exactly the cap long; the last burst carries the remainder.
- R4: Accepted words leave unchanged and in order, one per cycle, exactly one cycle after acceptance, with no control word inside a burst.
- R5: Bits 14:13 of the first control word after a packet's final data word are 2'b10 when both bytes are valid and 2'b11 when `in_odd` marked the last word as having one byte. They are 2'b00 in a control word that follows a burst ending mid-packet.
- R6: Two payload control words with start-of-packet set are at least 8 output cycles apart. Back-to-back one-word packets are exactly 8 cycles apart, with idle control words in between.
- R7: With `pad_en`=1, a packet of fewer than 32 words is followed by 16'h0000 data words up to 32 words, and its end status is 2'b10 whatever `in_odd` was. With `pad_en`=0 the packet leaves at its own length.
- R8: `in_ready` is 1 only in data cycles that take a word from the source. It is 0 in reset, in control cycles and while pad words are sent.
- R9: When a burst ends mid-packet and the rest of the packet is pending, the very next word is the payload control word of the following burst, so exactly one control word separates the two bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source word valid |
| in_ready | output | 1 | Word taken this cycle |
| in_data | input | 16 | Source data word |
| in_sop | input | 1 | Word is the first of a packet |
| in_eop | input | 1 | Word is the last of a packet |
| in_odd | input | 1 | Last word carries only its upper byte |
| in_port | input | PORT_W | Port address, constant over a packet |
| burst_sel | input | 1 | Selects which cap applies to the next burst |
| max_blk_a | input | BLK_W | Cap A in 16-byte blocks |
| max_blk_b | input | BLK_W | Cap B in 16-byte blocks |
| pad_en | input | 1 | Pad short packets to the minimum frame |
| tx_word | output | 16 | Transmit word |
| tx_ctl | output | 1 | Transmit word is a control word |

## Verification
The bench targets packets that end exactly on a cap boundary. A framer that tests the cap before end-of-packet would emit an extra empty burst or leave the end status clear. Padding that straddles a burst boundary comes next: a faulty design stops padding early or restarts a burst with the start-of-packet bit set again. A zero block count must act as one block rather than as an endless burst. Odd-length packets must show the one-byte status unless padding hides it. Back-to-back one-word packets must be held exactly eight cycles apart, and a design that counts the spacing from the wrong word sends them early or wastes extra idle cycles.

// File: rtl/tbf_pkg.sv
package tbf_pkg;

   localparam int CW_W = 16;

   typedef enum logic [1:0] {
      EOPS_NONE = 2'b00,
      EOPS_FULL = 2'b10,
      EOPS_HALF = 2'b11
   } eop_stat_e;

   typedef enum logic {
      FR_CTL  = 1'b0,
      FR_DATA = 1'b1
   } fr_state_e;

   function automatic logic [CW_W-1:0] make_ctl(input logic payload,
                                                input eop_stat_e est,
                                                input logic sop,
                                                input logic [7:0] port);
      return {payload, est, sop, port, 4'b0000};
   endfunction

endpackage

// File: rtl/tbf_sop_spacer.sv
module tbf_sop_spacer #(
   parameter int GAP = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sop_fire,
   output logic gap_ok
);
   localparam int CW = $clog2(GAP + 1);

   if (GAP < 1) begin : g_bad_gap
      $error("tbf_sop_spacer: GAP must be at least 1");
   end

   logic [CW-1:0] since_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_q <= CW'(GAP);
      end else if (sop_fire) begin
         since_q <= CW'(1);
      end else if (since_q != CW'(GAP)) begin
         since_q <= since_q + 1'b1;
      end
   end

   assign gap_ok = (since_q >= CW'(GAP));

   AST_GAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      sop_fire |=> !gap_ok); // R6

endmodule

// File: rtl/tbf_burst_ctr.sv
module tbf_burst_ctr #(
   parameter int BLK_W = 4,
   parameter int WPB   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             sel,
   input  logic [BLK_W-1:0] blk_a,
   input  logic [BLK_W-1:0] blk_b,
   input  logic             step,
   output logic             last
);
   localparam int LIM_W = BLK_W + $clog2(WPB) + 1;

   if (BLK_W < 1) begin : g_bad_blk
      $error("tbf_burst_ctr: BLK_W must be at least 1");
   end
   if (WPB < 1) begin : g_bad_wpb
      $error("tbf_burst_ctr: WPB must be at least 1");
   end

   logic [BLK_W-1:0] blk_pick;
   logic [LIM_W-1:0] blk_eff;
   logic [LIM_W-1:0] limit_q;
   logic [LIM_W-1:0] cnt_q;

   always_comb begin
      blk_pick = sel ? blk_b : blk_a;
      blk_eff  = (blk_pick == '0) ? LIM_W'(1) : LIM_W'(blk_pick);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         limit_q <= LIM_W'(WPB);
         cnt_q   <= '0;
      end else if (start) begin
         limit_q <= blk_eff * LIM_W'(WPB);
         cnt_q   <= '0;
      end else if (step) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign last = (cnt_q == limit_q - 1'b1);

   AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !last) |=> (cnt_q < limit_q)); // R3

endmodule

// File: rtl/tbf_pad_unit.sv
module tbf_pad_unit #(
   parameter int MIN_WORDS = 32,
   parameter bit ENABLE    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pkt_start,
   input  logic word_take,
   input  logic word_eop,
   input  logic pad_en,
   input  logic pad_step,
   output logic pad_room,
   output logic pad_active,
   output logic pad_last
);
   localparam int PC_W = $clog2(MIN_WORDS + 1);

   if (MIN_WORDS < 2) begin : g_bad_min
      $error("tbf_pad_unit: MIN_WORDS must be at least 2");
   end

   if (ENABLE) begin : g_pad
      logic [PC_W-1:0] pcnt_q;
      logic [PC_W-1:0] left_q;
      logic            act_q;

      assign pad_room   = pad_en && (pcnt_q < PC_W'(MIN_WORDS - 1));
      assign pad_active = act_q;
      assign pad_last   = (left_q == PC_W'(1));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pcnt_q <= '0;
            left_q <= '0;
            act_q  <= 1'b0;
         end else begin
            if (pkt_start) begin
               pcnt_q <= '0;
            end else if (word_take && pcnt_q != PC_W'(MIN_WORDS)) begin
               pcnt_q <= pcnt_q + 1'b1;
            end
            if (word_take && word_eop && pad_room) begin
               left_q <= PC_W'(MIN_WORDS - 1) - pcnt_q;
               act_q  <= 1'b1;
            end else if (pad_step) begin
               left_q <= left_q - 1'b1;
               if (left_q == PC_W'(1)) begin
                  act_q <= 1'b0;
               end
            end
         end
      end

      AST_PAD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
         (pad_step && pad_last) |=> !act_q); // R7
   end else begin : g_nopad
      logic unused_pad_in;
      assign unused_pad_in = ^{clk, rst_n, pkt_start, word_take, word_eop, pad_en, pad_step};
      assign pad_room   = 1'b0;
      assign pad_active = 1'b0;
      assign pad_last   = 1'b0;
   end

endmodule

// File: rtl/pkt_burst_framer.sv
module pkt_burst_framer
   import tbf_pkg::*;
#(
   parameter int               PORT_W          = 8,
   parameter int               BLK_W           = 4,
   parameter int               WORDS_PER_BLK   = 8,
   parameter int               MIN_FRAME_BYTES = 64,
   parameter int               SOP_GAP         = 8,
   parameter bit               PAD_ENABLE      = 1'b1,
   parameter logic [CW_W-1:0]  PAD_WORD        = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [CW_W-1:0]   in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic              in_odd,
   input  logic [PORT_W-1:0] in_port,
   input  logic              burst_sel,
   input  logic [BLK_W-1:0]  max_blk_a,
   input  logic [BLK_W-1:0]  max_blk_b,
   input  logic              pad_en,
   output logic [CW_W-1:0]   tx_word,
   output logic              tx_ctl
);
   localparam int MIN_WORDS = MIN_FRAME_BYTES / 2;

   if (PORT_W < 1 || PORT_W > 8) begin : g_bad_port
      $error("pkt_burst_framer: PORT_W must be 1..8");
   end
   if (MIN_FRAME_BYTES % 2 != 0) begin : g_bad_frame
      $error("pkt_burst_framer: MIN_FRAME_BYTES must be even");
   end

   fr_state_e         st_q;
   logic              in_pkt_q;
   logic [PORT_W-1:0] port_q;
   eop_stat_e         pend_q;

   logic gap_ok, burst_last;
   logic pad_room, pad_active, pad_last;
   logic can_new, can_cont, start;
   logic take, eop_word, pad_step, pkt_end;
   logic [PORT_W-1:0] ctl_port;
   logic [CW_W-1:0]   nxt_word;
   logic              nxt_ctl;

   always_comb begin
      can_new  = (st_q == FR_CTL) && !in_pkt_q && in_valid && in_sop && gap_ok;
      can_cont = (st_q == FR_CTL) && in_pkt_q && (pad_active || in_valid);
      start    = can_new || can_cont;
      in_ready = (st_q == FR_DATA) && !pad_active;
      take     = in_ready && in_valid;
      eop_word = take && in_eop;
      pad_step = (st_q == FR_DATA) && pad_active;
      pkt_end  = pad_step ? pad_last : (eop_word && !pad_room);
      ctl_port = start ? (can_new ? in_port : port_q) : '0;
   end

   always_comb begin
      if (st_q == FR_CTL) begin
         nxt_ctl  = 1'b1;
         nxt_word = make_ctl(start, pend_q, can_new, 8'(ctl_port));
      end else begin
         nxt_ctl  = 1'b0;
         nxt_word = pad_active ? PAD_WORD : in_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= FR_CTL;
         in_pkt_q <= 1'b0;
         port_q   <= '0;
         pend_q   <= EOPS_NONE;
         tx_word  <= '0;
         tx_ctl   <= 1'b1;
      end else begin
         tx_word <= nxt_word;
         tx_ctl  <= nxt_ctl;
         if (st_q == FR_CTL) begin
            pend_q <= EOPS_NONE;
            if (start) begin
               st_q <= FR_DATA;
            end
            if (can_new) begin
               in_pkt_q <= 1'b1;
               port_q   <= in_port;
            end
         end else begin
            if (pkt_end) begin
               st_q     <= FR_CTL;
               in_pkt_q <= 1'b0;
               pend_q   <= (pad_step || !in_odd) ? EOPS_FULL : EOPS_HALF;
            end else if (burst_last) begin
               st_q <= FR_CTL;
            end
         end
      end
   end

   tbf_sop_spacer #(.GAP(SOP_GAP)) u_spacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .sop_fire (can_new),
      .gap_ok   (gap_ok)
   );

   tbf_burst_ctr #(.BLK_W(BLK_W), .WPB(WORDS_PER_BLK)) u_burst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .sel   (burst_sel),
      .blk_a (max_blk_a),
      .blk_b (max_blk_b),
      .step  (st_q == FR_DATA),
      .last  (burst_last)
   );

   tbf_pad_unit #(.MIN_WORDS(MIN_WORDS), .ENABLE(PAD_ENABLE)) u_pad (
      .clk        (clk),
      .rst_n      (rst_n),
      .pkt_start  (can_new),
      .word_take  (take),
      .word_eop   (eop_word),
      .pad_en     (pad_en),
      .pad_step   (pad_step),
      .pad_room   (pad_room),
      .pad_active (pad_active),
      .pad_last   (pad_last)
   );

   // output-side observers for the checks below
   logic [15:0] chk_run_q;
   logic [7:0]  chk_sop_q;
   logic        out_sop;

   assign out_sop = tx_ctl && tx_word[15] && tx_word[12];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_run_q <= '0;
         chk_sop_q <= 8'(SOP_GAP);
      end else begin
         chk_run_q <= tx_ctl ? '0 : chk_run_q + 1'b1;
         if (out_sop) begin
            chk_sop_q <= 8'd1;
         end else if (chk_sop_q != 8'(SOP_GAP)) begin
            chk_sop_q <= chk_sop_q + 1'b1;
         end
      end
   end

   AST_DATA_AFTER_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ctl && tx_word[15]) |=> !tx_ctl); // R2

   AST_BURST_LED_BY_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_ctl) |-> $past(tx_word[15])); // R2

   AST_TAKEN_WORD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && in_valid) |=> (!tx_ctl && tx_word == $past(in_data))); // R4

   AST_SOP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      out_sop |-> (chk_sop_q >= 8'(SOP_GAP))); // R6

   AST_SHORT_BURST_ENDS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ctl && chk_run_q != '0 && (chk_run_q % 16'(WORDS_PER_BLK)) != '0)
         |-> (tx_word[14:13] != 2'b00)); // R3

endmodule

// File: tb/pkt_burst_framer_tb_top.sv
`timescale 1ns/1ps
module pkt_burst_framer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_data = '0;
   logic        in_sop = 1'b0;
   logic        in_eop = 1'b0;
   logic        in_odd = 1'b0;
   logic [7:0]  in_port = '0;
   logic        burst_sel = 1'b0;
   logic [3:0]  max_blk_a = 4'd2;
   logic [3:0]  max_blk_b = 4'd4;
   logic        pad_en = 1'b0;
   logic [15:0] tx_word;
   logic        tx_ctl;

   always #2 clk = ~clk;

   pkt_burst_framer dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_odd(in_odd),
      .in_port(in_port), .burst_sel(burst_sel), .max_blk_a(max_blk_a),
      .max_blk_b(max_blk_b), .pad_en(pad_en), .tx_word(tx_word), .tx_ctl(tx_ctl)
   );

   int n_tests = 0;
   int n_fail  = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // output log
   logic        lg_ctl  [0:1023];
   logic [15:0] lg_word [0:1023];
   int          lg_n = 0;
   bit          logging = 0;
   bit          saw_eop = 0;
   int          cyc = 0;
   int          last_sop_cyc = -1;
   int          last_gap = 0;

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_ctl && tx_word[15] && tx_word[12]) begin
            if (last_sop_cyc >= 0) begin
               last_gap = cyc - last_sop_cyc;
               chk(last_gap >= 8, "R6", "sop spacing", last_gap, 8);
            end
            last_sop_cyc = cyc;
         end
         if (logging && lg_n < 1024) begin
            lg_ctl[lg_n]  = tx_ctl;
            lg_word[lg_n] = tx_word;
            lg_n++;
            if (tx_ctl && tx_word[14:13] != 2'b00) saw_eop = 1;
         end
      end
   end

   task automatic send_pkt(input int len, input bit odd, input bit pad,
                           input bit sel, input logic [7:0] port,
                           input logic [15:0] base);
      int i = 0;
      bit acc;
      burst_sel = sel;
      pad_en    = pad;
      in_port   = port;
      while (i < len) begin
         in_valid = 1'b1;
         in_data  = base + 16'(i);
         in_sop   = (i == 0);
         in_eop   = (i == len - 1);
         in_odd   = (i == len - 1) && odd;
         acc      = in_ready;
         @(posedge clk);
         @(negedge clk);
         if (acc) i++;
      end
      in_valid = 1'b0;
      in_sop   = 1'b0;
      in_eop   = 1'b0;
      in_odd   = 1'b0;
   endtask

   task automatic wait_eop();
      int t = 0;
      while (!saw_eop && t < 600) begin
         @(negedge clk);
         t++;
      end
      chk(saw_eop, "R5", "end status seen", saw_eop, 1);
      logging = 0;
   endtask

   task automatic analyze(input int len, input bit odd, input bit pad,
                          input int maxw, input logic [7:0] port,
                          input logic [15:0] base, input string tag);
      int total = (pad && len < 32) ? 32 : len;
      int nb    = (total + maxw - 1) / maxw;
      int ecode = (total > len) ? 2 : (odd ? 3 : 2);
      int i = 0, nrun = 0, dcnt = 0, run = 0;
      bit done = 0;
      logic [15:0] expw;
      while (i < lg_n && !(lg_ctl[i] && lg_word[i][15])) i++;
      chk(i < lg_n, "R2", {tag, " payload ctl present"}, i, lg_n);
      while (i < lg_n && !done) begin
         chk(lg_word[i][12] == (nrun == 0), "R2", {tag, " sop bit"},
             int'(lg_word[i][12]), int'(nrun == 0));
         chk(lg_word[i][11:4] == port, "R2", {tag, " port field"},
             int'(lg_word[i][11:4]), int'(port));
         i++;
         run = 0;
         while (i < lg_n && !lg_ctl[i]) begin
            expw = (dcnt < len) ? base + 16'(dcnt) : 16'h0000;
            chk(lg_word[i] == expw, (dcnt < len) ? "R4" : "R7",
                {tag, " data word"}, int'(lg_word[i]), int'(expw));
            dcnt++; run++; i++;
         end
         chk(run > 0, "R2", {tag, " data right after payload ctl"}, run, 1);
         nrun++;
         if (i >= lg_n) begin
            done = 1;
         end else if (dcnt >= total) begin
            chk(run == total - (nb - 1) * maxw, "R3", {tag, " last burst length"},
                run, total - (nb - 1) * maxw);
            chk(int'(lg_word[i][14:13]) == ecode, "R5", {tag, " end status"},
                int'(lg_word[i][14:13]), ecode);
            done = 1;
         end else begin
            chk(run == maxw, "R3", {tag, " mid burst length"}, run, maxw);
            chk(lg_word[i][14:13] == 2'b00, "R5", {tag, " mid status"},
                int'(lg_word[i][14:13]), 0);
            chk(lg_word[i][15] == 1'b1, "R9", {tag, " next burst at once"},
                int'(lg_word[i][15]), 1);
         end
      end
      chk(dcnt == total, pad ? "R7" : "R4", {tag, " word count"}, dcnt, total);
      chk(nrun == nb, "R3", {tag, " burst count"}, nrun, nb);
   endtask

   task automatic run_pkt(input int len, input bit odd, input bit pad,
                          input bit sel, input logic [7:0] port,
                          input logic [15:0] base, input int maxw,
                          input string tag);
      lg_n = 0; saw_eop = 0; logging = 1;
      send_pkt(len, odd, pad, sel, port, base);
      wait_eop();
      analyze(len, odd, pad, maxw, port, base, tag);
   endtask

   typedef struct packed {
      logic [7:0] len;
      logic       odd;
      logic       pad;
      logic       sel;
      logic [7:0] port;
   } vec_t;

   // caps: A = 2 blocks (16 words), B = 4 blocks (32 words)
   localparam vec_t VECS [7] = '{
      '{8'd40, 1'b0, 1'b1, 1'b0, 8'h03},   // R3 three bursts
      '{8'd5,  1'b1, 1'b1, 1'b1, 8'h11},   // R7 pad hides odd
      '{8'd5,  1'b1, 1'b0, 1'b0, 8'h22},   // R5 odd, no pad
      '{8'd24, 1'b0, 1'b0, 1'b1, 8'h44},   // R4 single burst
      '{8'd33, 1'b1, 1'b1, 1'b1, 8'h5A},   // R3 one-word tail
      '{8'd10, 1'b0, 1'b1, 1'b0, 8'hA5},   // R7 pad across burst edge
      '{8'd16, 1'b1, 1'b0, 1'b0, 8'hFF}    // R3 eop on cap boundary
   };

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(tx_ctl == 1'b1, "R1", "ctl flag in reset", int'(tx_ctl), 1);
      chk(tx_word == 16'h0000, "R1", "idle word in reset", int'(tx_word), 0);
      chk(in_ready == 1'b0, "R8", "ready in reset", int'(in_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_ctl == 1'b1 && tx_word == 16'h0000, "R1", "idle after reset",
          int'(tx_word), 0);
      chk(in_ready == 1'b0, "R8", "ready idle", int'(in_ready), 0);

      foreach (VECS[k]) begin
         run_pkt(int'(VECS[k].len), VECS[k].odd, VECS[k].pad, VECS[k].sel,
                 VECS[k].port, 16'h1000 + 16'(k * 256),
                 VECS[k].sel ? 32 : 16, $sformatf("vec%0d", k));
      end

      // R6: two one-word packets back to back
      run_pkt(1, 1'b0, 1'b0, 1'b0, 8'h07, 16'h7000, 16, "sopA");
      run_pkt(1, 1'b1, 1'b0, 1'b0, 8'h08, 16'h7100, 16, "sopB");
      chk(last_gap == 8, "R6", "back-to-back sop distance", last_gap, 8);

      // R3: zero block count behaves as one block
      max_blk_a = 4'd0;
      run_pkt(20, 1'b0, 1'b0, 1'b0, 8'h30, 16'h3000, 8, "zeroblk");
      max_blk_a = 4'd2;

      // R8: ready stays low while padding
      lg_n = 0; saw_eop = 0; logging = 1;
      send_pkt(3, 1'b0, 1'b1, 1'b1, 8'h66, 16'h6600);
      for (int c = 0; c < 10; c++) begin
         chk(in_ready == 1'b0, "R8", "ready during padding", int'(in_ready), 0);
         @(negedge clk);
      end
      wait_eop();
      analyze(3, 1'b0, 1'b1, 32, 8'h66, 16'h6600, "padrdy");

      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule